// File: doc/BRIEF.md
# Configurable SPI Master Port

This block is a byte-wide SPI master that sits on a small register bus. Software picks the serial clock rate, the level the clock rests at between transfers, the clock edge on which outgoing data changes, and whether incoming data is captured in the middle or at the end of each bit. Writing a byte to the data register starts an 8-bit exchange. The byte goes out on the serial data output, most significant bit first, while 8 bits are gathered from the serial data input. When the exchange finishes, the gathered byte replaces the contents of the data register, a full flag is raised and a one-cycle completion pulse is given for use as an interrupt source.

The serial clock is derived from the system clock by one of three fixed dividers, or it is stepped by an external timer tick. An enable bit hands the serial pins to the port. While the enable bit is clear, the output enables are low so the pins can serve as general I/O, and no exchange runs. Chip select is not produced here. A general-purpose output drives it.

The register map has four locations. CONFIG at address 0 is read/write: bits [3:0] rate mode, bit 4 idle level, bit 5 transmit edge, bit 6 sample point, bit 7 enable. STATUS at address 1 holds bit 0 full, bit 1 write collision, bit 2 overflow and bit 3 busy. DATA is at address 2. Address 3 reads as zero.

Top module: `spi_master_port`

## Requirements
- R1: CONFIG[1:0] sets the serial clock half-period. 00 gives 2 system clocks (clk/4), 01 gives 8 (clk/16) and 10 gives 32 (clk/64). CONFIG[3:2] are stored and read back but do not affect the rate.
- R2: With CONFIG[1:0] = 11, each cycle in which `tmr_tick` is high during a transfer advances the serial clock by one half-period.
- R3: While no transfer runs, `sck` rests at CONFIG[4] (1 = high, 0 = low). A transfer makes exactly 16 `sck` edges and leaves `sck` back at that level.
- R4: Data leaves MSB first, 8 bits per transfer. With CONFIG[5] = 1, `sdo` changes on the edge that leaves the idle level: rising when the idle level is low, falling when it is high. With CONFIG[5] = 0, `sdo` changes on the edge that returns to the idle level, and the MSB is on `sdo` from the start of the transfer.
- R5: CONFIG[6] = 0 captures `sdi` in the middle of each bit's output time, on the edge opposite the transmit edge. CONFIG[6] = 1 captures at the end of the output time. That is the next transmit edge, or, for the last bit with CONFIG[5] = 1, one half-period after the final edge.
- R6: A write to DATA while the port is enabled and idle starts a transfer. At its end the received byte replaces the DATA contents and STATUS[0] (full) is set.
- R7: A read of DATA returns the stored byte and clears STATUS[0].
- R8: A write to DATA while busy sets STATUS[1] (write collision). The written byte is dropped and the running transfer continues unchanged. STATUS[1] stays set until STATUS is written with bit 1 = 0.
- R9: STATUS[2] (overflow) always reads 0, even when a transfer completes while STATUS[0] is already set.
- R10: `xfer_done` is high for exactly one cycle per completed transfer.
- R11: CONFIG[7] drives `sck_oe` and `sdo_oe`. While it is 0, a write to DATA loads the register but starts no transfer. Clearing it during a transfer aborts the transfer with no completion pulse.
- R12: After reset, CONFIG, STATUS and DATA read 0, `sck` is 0, and both output enables are 0.
- R13: `bus_rdata` is registered and shows the addressed register in the cycle after `bus_rd`. STATUS[3] shows busy and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tmr_tick | input | 1 | External timer tick for rate mode 11 |
| sdi | input | 1 | Serial data in |
| sck | output | 1 | Serial clock |
| sck_oe | output | 1 | Serial clock output enable |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| xfer_done | output | 1 | One-cycle completion pulse |

## Verification
The bench acts as a slave. Its input bit is correct only at the configured capture point and inverted at the other. A port that captures in the middle instead of at the end, or the reverse, therefore returns the complemented byte. It also records `sdo` on the edge opposite the transmit edge. A port that changes data on the wrong edge therefore shows a shifted byte, and one that sends LSB first shows a reversed byte. The slave checks all four combinations of idle level and transmit edge, and it measures the half-period for every rate mode, including the timer tick. It also covers a write while busy, a second completion before a read, a write while disabled and an abort in the middle of a transfer. A design that loses the original byte, lets the overflow bit rise, starts a transfer while disabled or pulses `xfer_done` after an abort is caught by a register read-back or by a count of pulses and edges.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;

  localparam int BYTE_W = 8;

  localparam logic [1:0] ADDR_CFG  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int ST_FULL = 0;
  localparam int ST_WCOL = 1;
  localparam int ST_OVF  = 2;
  localparam int ST_BUSY = 3;

  typedef enum logic [1:0] {
    RATE_DIV4  = 2'd0,
    RATE_DIV16 = 2'd1,
    RATE_DIV64 = 2'd2,
    RATE_TIMER = 2'd3
  } rate_e;

  typedef struct packed {
    logic       en;
    logic       sample_end;
    logic       tx_lead;
    logic       idle_high;
    logic [3:0] mode;
  } cfg_t;

endpackage

// File: rtl/spi_clk_gen.sv
`timescale 1ns/1ps
module spi_clk_gen
  import spi_port_pkg::*;
#(
  parameter int HALF_FAST = 2,
  parameter int HALF_MID  = 8,
  parameter int HALF_SLOW = 32
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  run,
  input  rate_e rate,
  input  logic  ext_tick,
  output logic  tick
);
  localparam int CNT_W = (HALF_SLOW > 2) ? $clog2(HALF_SLOW) : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] limit;
  logic             at_limit;

  always_comb begin
    case (rate)
      RATE_DIV4:  limit = CNT_W'(HALF_FAST - 1);
      RATE_DIV16: limit = CNT_W'(HALF_MID - 1);
      default:    limit = CNT_W'(HALF_SLOW - 1);
    endcase
  end

  assign at_limit = (cnt == limit);
  assign tick     = run && ((rate == RATE_TIMER) ? ext_tick : at_limit);

  always_ff @(posedge clk) begin
    if (rst || !run || rate == RATE_TIMER) begin
      cnt <= '0;
    end else if (at_limit) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

// File: rtl/spi_shift_engine.sv
`timescale 1ns/1ps
module spi_shift_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              start,
  input  logic [DATA_W-1:0] load_byte,
  input  logic              tick,
  input  logic              idle_high,
  input  logic              tx_lead,
  input  logic              sample_end,
  input  logic              sdi,
  output logic              busy,
  output logic              sck,
  output logic              sdo,
  output logic              done,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int             EDGES     = 2 * DATA_W;
  localparam int             PH_W      = $clog2(EDGES + 2);
  localparam logic [PH_W-1:0] LAST_EDGE = PH_W'(EDGES);

  logic [PH_W-1:0]   ph;
  logic [PH_W-1:0]   nph;
  logic [PH_W-1:0]   last_ph;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic              sck_q, sdo_q, busy_q, done_q;
  logic              do_toggle, do_sample, do_shift;

  assign nph     = ph + 1'b1;
  assign last_ph = LAST_EDGE + PH_W'(tx_lead & sample_end);

  // Edge index nph: odd = leaving idle, even = returning to idle
  assign do_toggle = (nph <= LAST_EDGE);
  assign do_sample = (nph[0] ^ tx_lead ^ sample_end) &&
                     !(tx_lead && sample_end && nph == PH_W'(1));
  assign do_shift  = (nph[0] == tx_lead) && (nph >= PH_W'(2)) && (nph < LAST_EDGE);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      sck_q  <= 1'b0;
      sdo_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!enable) begin
        busy_q <= 1'b0;
        ph     <= '0;
        sck_q  <= idle_high;
      end else if (!busy_q) begin
        sck_q <= idle_high;
        if (start) begin
          busy_q <= 1'b1;
          ph     <= '0;
          sdo_q  <= load_byte[DATA_W-1];
          tx_sh  <= {load_byte[DATA_W-2:0], 1'b0};
        end
      end else if (tick) begin
        ph <= nph;
        if (do_toggle) sck_q <= ~sck_q;
        if (do_sample) rx_sh <= {rx_sh[DATA_W-2:0], sdi};
        if (do_shift) begin
          sdo_q <= tx_sh[DATA_W-1];
          tx_sh <= {tx_sh[DATA_W-2:0], 1'b0};
        end
        if (nph == last_ph) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy    = busy_q;
  assign sck     = sck_q;
  assign sdo     = sdo_q;
  assign done    = done_q;
  assign rx_byte = rx_sh;

endmodule

// File: rtl/spi_port_regs.sv
`timescale 1ns/1ps
module spi_port_regs
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  output cfg_t              cfg,
  output logic              start,
  output logic [BYTE_W-1:0] load_byte,
  output logic              full,
  output logic              wcol
);
  logic [BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0] rdata_q;
  logic [BYTE_W-1:0] stat_view;
  logic              wr_data;

  assign wr_data   = bus_wr && (bus_addr == ADDR_DATA);
  assign start     = wr_data && cfg.en && !busy;
  assign load_byte = bus_wdata;

  always_comb begin
    stat_view          = '0;
    stat_view[ST_FULL] = full;
    stat_view[ST_WCOL] = wcol;
    stat_view[ST_OVF]  = 1'b0;
    stat_view[ST_BUSY] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg     <= '0;
      data_q  <= '0;
      full    <= 1'b0;
      wcol    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (bus_wr && bus_addr == ADDR_CFG) cfg <= cfg_t'(bus_wdata);

      if (wr_data) begin
        if (busy) wcol <= 1'b1;
        else      data_q <= bus_wdata;
      end else if (bus_wr && bus_addr == ADDR_STAT && !bus_wdata[ST_WCOL]) begin
        wcol <= 1'b0;
      end

      if (done) begin
        data_q <= rx_byte;
        full   <= 1'b1;
      end else if (bus_rd && bus_addr == ADDR_DATA) begin
        full <= 1'b0;
      end

      if (bus_rd) begin
        case (bus_addr)
          ADDR_CFG:  rdata_q <= cfg;
          ADDR_STAT: rdata_q <= stat_view;
          ADDR_DATA: rdata_q <= data_q;
          default:   rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;

endmodule

// File: rtl/spi_master_port.sv
`timescale 1ns/1ps
module spi_master_port
  import spi_port_pkg::*;
#(
  parameter int HALF_FAST = 2,
  parameter int HALF_MID  = 8,
  parameter int HALF_SLOW = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       tmr_tick,
  input  logic       sdi,
  output logic       sck,
  output logic       sck_oe,
  output logic       sdo,
  output logic       sdo_oe,
  output logic       xfer_done
);
  cfg_t              cfg;
  logic              start, eng_busy, eng_done, half_tick;
  logic              stat_full, stat_wcol;
  logic [BYTE_W-1:0] load_byte, rx_byte;
  logic              cfg_en, cfg_idle;

  assign cfg_en   = cfg.en;
  assign cfg_idle = cfg.idle_high;

  spi_port_regs regs_i (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .busy      (eng_busy),
    .done      (eng_done),
    .rx_byte   (rx_byte),
    .cfg       (cfg),
    .start     (start),
    .load_byte (load_byte),
    .full      (stat_full),
    .wcol      (stat_wcol)
  );

  spi_clk_gen #(
    .HALF_FAST (HALF_FAST),
    .HALF_MID  (HALF_MID),
    .HALF_SLOW (HALF_SLOW)
  ) clkgen_i (
    .clk      (clk),
    .rst      (rst),
    .run      (eng_busy),
    .rate     (rate_e'(cfg.mode[1:0])),
    .ext_tick (tmr_tick),
    .tick     (half_tick)
  );

  spi_shift_engine #(
    .DATA_W (BYTE_W)
  ) engine_i (
    .clk        (clk),
    .rst        (rst),
    .enable     (cfg_en),
    .start      (start),
    .load_byte  (load_byte),
    .tick       (half_tick),
    .idle_high  (cfg.idle_high),
    .tx_lead    (cfg.tx_lead),
    .sample_end (cfg.sample_end),
    .sdi        (sdi & cfg_en),
    .busy       (eng_busy),
    .sck        (sck),
    .sdo        (sdo),
    .done       (eng_done),
    .rx_byte    (rx_byte)
  );

  assign sck_oe    = cfg_en;
  assign sdo_oe    = cfg_en;
  assign xfer_done = eng_done;

endmodule

// File: rtl/spi_master_port_chk.sv
`timescale 1ns/1ps
module spi_master_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       wdata_wcol_bit,
  input logic       xfer_done,
  input logic       sck,
  input logic       busy,
  input logic       wcol,
  input logic       full,
  input logic       idle_high,
  input logic       port_en
);
  // R10: completion is a single-cycle pulse
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> !xfer_done);

  // R6: completion raises the full flag
  p_done_full_r6: assert property (@(posedge clk) disable iff (rst)
    xfer_done |=> full);

  // R8: data write during a transfer flags a collision
  p_wcol_set_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr == 2'd2 && busy) |=> wcol);

  // R8: collision flag only falls on a clearing status write
  p_wcol_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (wcol && !(bus_wr && bus_addr == 2'd1 && !wdata_wcol_bit)) |=> wcol);

  // R3: clock rests at the configured level when idle
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (rst)
    !busy |=> (sck == $past(idle_high)));

  // R11: a disabled port neither runs nor completes
  p_disabled_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !port_en |=> (!busy && !xfer_done));
endmodule

bind spi_master_port spi_master_port_chk chk_i (
  .clk            (clk),
  .rst            (rst),
  .bus_wr         (bus_wr),
  .bus_addr       (bus_addr),
  .wdata_wcol_bit (bus_wdata[1]),
  .xfer_done      (xfer_done),
  .sck            (sck),
  .busy           (eng_busy),
  .wcol           (stat_wcol),
  .full           (stat_full),
  .idle_high      (cfg_idle),
  .port_en        (cfg_en)
);

// File: tb/spi_master_port_tb_top.sv
`timescale 1ns/1ps
module spi_master_port_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       tmr_tick = 1'b0;
  logic       sdi = 1'b0;
  logic       sck, sck_oe, sdo, sdo_oe, xfer_done;

  int n_chk = 0, n_fail = 0;
  int done_cnt = 0, cyc = 0;

  // slave model state
  logic       slave_on = 1'b0;
  logic       cfg_idle = 1'b0, cfg_lead = 1'b0, cfg_mid = 1'b1;
  logic [7:0] slv_tx = 8'd0, slv_rx = 8'd0;
  int         slv_j = 0, edge_cnt = 0;
  real        t1 = 0.0, t2 = 0.0;

  spi_master_port dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tmr_tick(tmr_tick), .sdi(sdi),
    .sck(sck), .sck_oe(sck_oe), .sdo(sdo), .sdo_oe(sdo_oe), .xfer_done(xfer_done)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (xfer_done) done_cnt <= done_cnt + 1;
  end

  // timer tick: one cycle high out of every three
  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k + 1) % 3;
      tmr_tick = (k == 0);
    end
  end

  // slave: presents each bit correctly only at the configured capture point
  always @(sck) begin
    if (slave_on) begin
      logic lead_edge;
      edge_cnt = edge_cnt + 1;
      if (edge_cnt == 1) t1 = $realtime;
      if (edge_cnt == 2) t2 = $realtime;
      lead_edge = (sck != cfg_idle);
      #1;
      if (lead_edge == cfg_lead) begin
        slv_j = slv_j + 1;
        if (slv_j >= 0 && slv_j < 8) sdi = cfg_mid ? slv_tx[7-slv_j] : ~slv_tx[7-slv_j];
      end else begin
        slv_rx = {slv_rx[6:0], sdo};
        if (slv_j >= 0 && slv_j < 8) sdi = cfg_mid ? ~slv_tx[7-slv_j] : slv_tx[7-slv_j];
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_done(input int max_cyc);
    for (int i = 0; i < max_cyc && done_cnt == 0; i++) @(negedge clk);
  endtask

  task automatic arm_slave(input logic idle, input logic lead, input logic send_end,
                           input logic [7:0] stx);
    cfg_idle = idle; cfg_lead = lead; cfg_mid = !send_end;
    slv_tx = stx; slv_rx = 8'd0; edge_cnt = 0; done_cnt = 0;
    slv_j = lead ? -1 : 0;
    sdi = lead ? 1'b0 : (cfg_mid ? stx[7] : ~stx[7]);
    slave_on = 1'b1;
  endtask

  // one full exchange; checks R1/R2 rate, R3, R4, R5, R6, R7, R10
  task automatic do_xfer(input logic [3:0] mode, input logic idle, input logic lead,
                         input logic send_end, input logic [7:0] mtx, input logic [7:0] stx,
                         input int exp_half, input string rate_req, input bit do_read);
    logic [7:0] d;
    bus_write(2'd0, {1'b1, send_end, lead, idle, mode});
    repeat (3) @(negedge clk);
    chk("R11", sck_oe, 1, "sck_oe when enabled");
    chk("R3", sck, idle, "idle level before transfer");
    arm_slave(idle, lead, send_end, stx);
    bus_write(2'd2, mtx);
    wait_done(2000);
    repeat (4) @(negedge clk);
    slave_on = 1'b0;
    chk("R4", slv_rx, mtx, "byte seen by slave on sdo");
    chk(rate_req, $rtoi((t2 - t1) / 5.0 + 0.5), exp_half, "sck half-period in cycles");
    chk("R3", edge_cnt, 16, "sck edges per transfer");
    chk("R3", sck, idle, "sck back at idle level");
    chk("R10", done_cnt, 1, "completion pulses");
    if (do_read) begin
      bus_read(2'd1, d);
      chk("R6", d[0], 1, "full flag after transfer");
      bus_read(2'd2, d);
      chk("R5", d, stx, "received byte at chosen sample point");
      bus_read(2'd1, d);
      chk("R7", d[0], 0, "full cleared by data read");
    end
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R12", sck, 0, "sck after reset");
    chk("R12", sck_oe, 0, "sck_oe after reset");
    chk("R12", sdo_oe, 0, "sdo_oe after reset");
    bus_read(2'd0, d); chk("R12", d, 0, "config after reset");
    bus_read(2'd1, d); chk("R12", d, 0, "status after reset");
    bus_read(2'd2, d); chk("R12", d, 0, "data after reset");
    bus_read(2'd3, d); chk("R13", d, 0, "unused address");
  endtask

  task automatic t_modes;
    logic [7:0] d;
    do_xfer(4'b0000, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 2,  "R1", 1'b1);
    do_xfer(4'b1101, 1'b1, 1'b1, 1'b1, 8'h96, 8'hC3, 8,  "R1", 1'b1);
    bus_read(2'd0, d);
    chk("R1", d[3:0], 4'hD, "upper mode bits stored");
    do_xfer(4'b0010, 1'b0, 1'b1, 1'b0, 8'h0F, 8'h81, 32, "R1", 1'b1);
    do_xfer(4'b0011, 1'b1, 1'b0, 1'b1, 8'hF0, 8'h5A, 3,  "R2", 1'b1);
    do_xfer(4'b0000, 1'b0, 1'b0, 1'b1, 8'h01, 8'h80, 2,  "R5", 1'b1);
    do_xfer(4'b0000, 1'b1, 1'b1, 1'b0, 8'h6E, 8'hE7, 2,  "R4", 1'b1);
    do_xfer(4'b0000, 1'b0, 1'b1, 1'b1, 8'hB2, 8'h4D, 2,  "R5", 1'b1);
  endtask

  task automatic t_collision;
    logic [7:0] d;
    bus_write(2'd0, 8'h82);
    repeat (3) @(negedge clk);
    arm_slave(1'b0, 1'b0, 1'b0, 8'h99);
    bus_write(2'd2, 8'hC6);
    repeat (40) @(negedge clk);
    bus_write(2'd2, 8'h39);
    bus_read(2'd1, d);
    chk("R8", d[1], 1, "collision flag on busy write");
    chk("R13", d[3], 1, "busy shown in status");
    wait_done(2000);
    repeat (4) @(negedge clk);
    slave_on = 1'b0;
    chk("R8", slv_rx, 8'hC6, "original byte kept on sdo");
    chk("R10", done_cnt, 1, "one pulse despite collision");
    bus_read(2'd2, d);
    chk("R8", d, 8'h99, "dropped byte did not reach data register");
    bus_write(2'd1, 8'hFF);
    bus_read(2'd1, d);
    chk("R8", d[1], 1, "collision flag holds on write of 1");
    bus_write(2'd1, 8'h00);
    bus_read(2'd1, d);
    chk("R8", d[1], 0, "collision flag cleared");
  endtask

  task automatic t_overflow;
    logic [7:0] d;
    do_xfer(4'b0000, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22, 2, "R1", 1'b0);
    do_xfer(4'b0000, 1'b0, 1'b0, 1'b0, 8'h33, 8'h44, 2, "R1", 1'b0);
    bus_read(2'd1, d);
    chk("R9", d, 8'h01, "status after unread second byte (overflow bit 2 low)");
    bus_read(2'd2, d);
    chk("R6", d, 8'h44, "latest received byte");
  endtask

  task automatic t_disable;
    logic [7:0] d;
    bus_write(2'd0, 8'h00);
    repeat (3) @(negedge clk);
    arm_slave(1'b0, 1'b0, 1'b0, 8'h00);
    bus_write(2'd2, 8'h55);
    repeat (100) @(negedge clk);
    slave_on = 1'b0;
    chk("R11", edge_cnt, 0, "no sck edges while disabled");
    chk("R11", done_cnt, 0, "no completion while disabled");
    chk("R11", sdo_oe, 0, "sdo_oe while disabled");
    bus_read(2'd2, d);
    chk("R11", d, 8'h55, "data register loaded while disabled");
    // abort in mid-transfer
    bus_write(2'd0, 8'h82);
    repeat (3) @(negedge clk);
    done_cnt = 0;
    bus_write(2'd2, 8'hAA);
    repeat (50) @(negedge clk);
    bus_read(2'd1, d);
    chk("R13", d[3], 1, "busy during transfer");
    bus_write(2'd0, 8'h02);
    repeat (600) @(negedge clk);
    chk("R11", done_cnt, 0, "no pulse after abort");
    chk("R11", sck_oe, 0, "sck_oe after abort");
    bus_read(2'd1, d);
    chk("R11", d[3], 0, "not busy after abort");
    do_xfer(4'b0001, 1'b0, 1'b1, 1'b0, 8'h5C, 8'hA3, 8, "R1", 1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog (all requirements) actual=150000 cycles expected=end of tests");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_modes();
    t_collision();
    t_overflow();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule